// File: doc/BRIEF.md
# Ten-Channel Toggle Controller with Channel Display

This block controls ten on/off load channels from two push buttons. A step button moves a channel pointer forward by one channel per press. After the last channel the pointer returns to channel 0. The pointer is kept both as a one-hot select vector and as a decimal digit. The digit drives a seven-segment display, so the operator can see which channel is active.

A toggle button flips the latched on/off state of the channel under the pointer and leaves every other channel alone. Both button inputs come in raw. Each passes through a two-flop synchronizer and a stability filter, and each accepted press becomes one single-cycle pulse at its rising edge. The only way to return the pointer to 0 is the power-on reset or a full trip around the channels. There is no separate reset button.

Top module: `toggle_bank`

## Requirements
- R1: While and after reset (active-low `rst_n`), `chan_sel` equals 10'b0000000001, `seg` shows digit 0 and every bit of `chan_on` is 0.
- R2: Each accepted step press moves the pointer forward by exactly one channel.
- R3: When the pointer is at channel 9, a step press moves it to channel 0.
- R4: Exactly one bit of `chan_sel` is high at all times, and that bit's index equals the digit on the display.
- R5: Each accepted toggle press inverts bit i of `chan_on`, where i is the selected channel.
- R6: A toggle press leaves every `chan_on` bit of an unselected channel unchanged, and a step press changes no `chan_on` bit.
- R7: A button level that stays changed for fewer than `DEB_CYCLES` cycles after synchronization has no effect. Holding a button down produces exactly one action.
- R8: Releasing a button causes no action. Only the debounced rising edge acts.
- R9: `seg` is active-high with bit 0 = segment a through bit 6 = segment g. Digits 0..9 show 0x3F, 0x06, 0x5B, 0x4F, 0x66, 0x6D, 0x7D, 0x07, 0x7F, 0x6F.
- R10: When a step press and a toggle press are accepted in the same cycle, the toggle acts on the channel that was selected before the step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low power-on reset |
| step_btn | input | 1 | Raw step push button, high when pressed |
| toggle_btn | input | 1 | Raw toggle push button, high when pressed |
| chan_on | output | 10 | Latched on/off state of each channel |
| chan_sel | output | 10 | One-hot select vector of the active channel |
| seg | output | 7 | Seven-segment lines a..g, active-high |

## Verification
The step button is pressed eleven times in a row. This walks the pointer through every digit and back to 0, which separates a correct wrap from stopping at 9 or counting past it, and checks every display pattern. Toggles are applied on several different channels, twice on one of them, so that flipping the wrong bit, flipping several bits or setting instead of inverting all show up. Glitches shorter than the filter window, long holds and releases each test that one press gives exactly one action. A press of both buttons in the same cycle separates applying the toggle before the step from applying it after.

// File: rtl/toggle_bank_pkg.sv
package toggle_bank_pkg;

  // Seven-segment pattern, bit 0 = segment a ... bit 6 = segment g
  function automatic logic [6:0] digit_to_seg(input logic [3:0] d);
    logic [6:0] s;
    case (d)
      4'd0: s = 7'h3F;
      4'd1: s = 7'h06;
      4'd2: s = 7'h5B;
      4'd3: s = 7'h4F;
      4'd4: s = 7'h66;
      4'd5: s = 7'h6D;
      4'd6: s = 7'h7D;
      4'd7: s = 7'h07;
      4'd8: s = 7'h7F;
      4'd9: s = 7'h6F;
      default: s = 7'h00;
    endcase
    return s;
  endfunction

  // Wrapping advance of a pointer over n positions
  function automatic logic [3:0] next_index(input logic [3:0] cur, input int n);
    return (int'(cur) == n - 1) ? 4'd0 : cur + 4'd1;
  endfunction

endpackage

// File: rtl/btn_conditioner.sv
module btn_conditioner #(
  parameter int DEB_CYCLES = 65536
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  output logic press
);
  localparam int CW = $clog2(DEB_CYCLES) + 1;
  localparam logic [CW-1:0] LAST = CW'(DEB_CYCLES - 1);

  logic [1:0]    sync_q;
  logic          stable_q;
  logic [CW-1:0] cnt_q;
  logic          level_s;
  logic          accept_s;

  assign level_s  = sync_q[1];
  assign accept_s = (level_s != stable_q) && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q   <= 2'b00;
      stable_q <= 1'b0;
      cnt_q    <= '0;
      press    <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], raw};
      press  <= accept_s && level_s;
      if (level_s == stable_q) begin
        cnt_q <= '0;
      end else if (accept_s) begin
        stable_q <= level_s;
        cnt_q    <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // R7: a press lasts one cycle and only follows a full stable window
  assert_press_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    press |=> !press);
  assert_press_after_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
    press |-> ($past(cnt_q) == LAST && stable_q));

endmodule

// File: rtl/chan_pointer.sv
module chan_pointer
  import toggle_bank_pkg::*;
#(
  parameter int NUM_CH = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  output logic [3:0]        idx,
  output logic [NUM_CH-1:0] sel
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx <= 4'd0;
      sel <= NUM_CH'(1);
    end else if (step) begin
      idx <= next_index(idx, NUM_CH);
      sel <= {sel[NUM_CH-2:0], sel[NUM_CH-1]};
    end
  end

  // R4: one-hot, matching the digit
  assert_sel_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(sel) == 1);
  assert_sel_matches_digit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sel[idx] == 1'b1);
  // R2 / R3: advance by one, wrap at the last channel
  assert_step_advance_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (step && int'(idx) != NUM_CH - 1) |=> idx == $past(idx) + 4'd1);
  assert_step_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (step && int'(idx) == NUM_CH - 1) |=> idx == 4'd0);
  assert_hold_without_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(idx));

endmodule

// File: rtl/toggle_bank.sv
module toggle_bank
  import toggle_bank_pkg::*;
#(
  parameter int NUM_CH     = 10,
  parameter int DEB_CYCLES = 65536
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_btn,
  input  logic              toggle_btn,
  output logic [NUM_CH-1:0] chan_on,
  output logic [NUM_CH-1:0] chan_sel,
  output logic [6:0]        seg
);
  logic       step_pulse;
  logic       toggle_pulse;
  logic [3:0] cur_idx;

  btn_conditioner #(.DEB_CYCLES(DEB_CYCLES)) u_step_cond (
    .clk(clk), .rst_n(rst_n), .raw(step_btn), .press(step_pulse)
  );

  btn_conditioner #(.DEB_CYCLES(DEB_CYCLES)) u_toggle_cond (
    .clk(clk), .rst_n(rst_n), .raw(toggle_btn), .press(toggle_pulse)
  );

  chan_pointer #(.NUM_CH(NUM_CH)) u_ptr (
    .clk(clk), .rst_n(rst_n), .step(step_pulse), .idx(cur_idx), .sel(chan_sel)
  );

  // One toggle latch per channel, enabled by its select line
  for (genvar i = 0; i < NUM_CH; i++) begin : g_latch
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chan_on[i] <= 1'b0;
      else if (toggle_pulse && chan_sel[i]) chan_on[i] <= ~chan_on[i];
    end
  end

  assign seg = digit_to_seg(cur_idx);

  // R5 / R10: the channel selected in the pulse cycle flips
  assert_toggle_selected_R5: assert property (@(posedge clk) disable iff (!rst_n)
    toggle_pulse |=> chan_on == ($past(chan_on) ^ $past(chan_sel)));
  // R6: without a toggle no channel moves
  assert_no_toggle_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !toggle_pulse |=> $stable(chan_on));
  // R9: display never dark
  assert_seg_lit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    seg != 7'h00);

endmodule

// File: tb/toggle_bank_test.sv
module toggle_bank_test;
  localparam int N   = 10;
  localparam int DEB = 8;
  localparam int SETTLE = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic step_btn = 1'b0;
  logic toggle_btn = 1'b0;
  logic [N-1:0] chan_on;
  logic [N-1:0] chan_sel;
  logic [6:0]   seg;

  int checks = 0;
  int errors = 0;
  int exp_ptr = 0;
  logic [N-1:0] exp_on = '0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  toggle_bank #(.NUM_CH(N), .DEB_CYCLES(DEB)) uut (
    .clk(clk), .rst_n(rst_n), .step_btn(step_btn), .toggle_btn(toggle_btn),
    .chan_on(chan_on), .chan_sel(chan_sel), .seg(seg)
  );

  // Expected pattern built from the lit segments of each digit
  function automatic logic [6:0] exp_seg(input int d);
    // segment names: a=0 b=1 c=2 d=3 e=4 f=5 g=6
    case (d)
      0: return 7'b0111111;
      1: return 7'b0000110;
      2: return 7'b1011011;
      3: return 7'b1001111;
      4: return 7'b1100110;
      5: return 7'b1101101;
      6: return 7'b1111101;
      7: return 7'b0000111;
      8: return 7'b1111111;
      9: return 7'b1101111;
      default: return 7'b0000000;
    endcase
  endfunction

  task automatic check_state(input string req);
    logic [N-1:0] es;
    es = '0;
    es[exp_ptr] = 1'b1;
    checks++;
    if (chan_sel !== es) begin
      errors++;
      $display("FAIL %s chan_sel actual %b expected %b", req, chan_sel, es);
    end
    checks++;
    if (seg !== exp_seg(exp_ptr)) begin
      errors++;
      $display("FAIL %s seg actual %h expected %h", req, seg, exp_seg(exp_ptr));
    end
    checks++;
    if (chan_on !== exp_on) begin
      errors++;
      $display("FAIL %s chan_on actual %b expected %b", req, chan_on, exp_on);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic press(input bit do_step, input bit do_tog);
    @(negedge clk);
    step_btn = do_step;
    toggle_btn = do_tog;
    wait_cyc(SETTLE);
    step_btn = 1'b0;
    toggle_btn = 1'b0;
    wait_cyc(SETTLE);
  endtask

  // R1
  task automatic t_reset();
    rst_n = 1'b0;
    wait_cyc(3);
    exp_ptr = 0; exp_on = '0;
    check_state("R1 during reset");
    rst_n = 1'b1;
    wait_cyc(5);
    check_state("R1 after reset");
  endtask

  // R2, R3, R4, R9: eleven steps cover every digit and the wrap
  task automatic t_step_walk();
    for (int k = 0; k < 11; k++) begin
      press(1'b1, 1'b0);
      exp_ptr = (exp_ptr + 1) % N;
      check_state(exp_ptr == 0 ? "R3 wrap" : "R2 R4 R9 step");
    end
  endtask

  // R5, R6: toggles on several channels
  task automatic t_toggles();
    press(1'b0, 1'b1);               // channel 1 on
    exp_on[exp_ptr] ^= 1'b1;
    check_state("R5 toggle ch1");
    for (int k = 0; k < 4; k++) begin
      press(1'b1, 1'b0);
      exp_ptr = (exp_ptr + 1) % N;
    end
    check_state("R6 step keeps states");
    press(1'b0, 1'b1);               // channel 5 on
    exp_on[exp_ptr] ^= 1'b1;
    check_state("R5 toggle ch5");
    press(1'b0, 1'b1);               // channel 5 off again
    exp_on[exp_ptr] ^= 1'b1;
    check_state("R5 R6 second toggle ch5");
    press(1'b0, 1'b1);
    exp_on[exp_ptr] ^= 1'b1;
    check_state("R5 retoggle ch5");
  endtask

  // R7: short glitches ignored, long hold acts once
  task automatic t_debounce();
    for (int w = 1; w <= 3; w++) begin
      @(negedge clk);
      toggle_btn = 1'b1; step_btn = 1'b1;
      wait_cyc(w);
      toggle_btn = 1'b0; step_btn = 1'b0;
      wait_cyc(SETTLE);
      check_state("R7 glitch ignored");
    end
    @(negedge clk);
    step_btn = 1'b1;
    wait_cyc(300);
    exp_ptr = (exp_ptr + 1) % N;
    check_state("R7 held step acts once");
    // R8: release takes no action
    step_btn = 1'b0;
    wait_cyc(SETTLE);
    check_state("R8 release no action");
    @(negedge clk);
    toggle_btn = 1'b1;
    wait_cyc(300);
    exp_on[exp_ptr] ^= 1'b1;
    check_state("R7 held toggle acts once");
    toggle_btn = 1'b0;
    wait_cyc(SETTLE);
    check_state("R8 toggle release no action");
  endtask

  // R10: both buttons at once
  task automatic t_simultaneous();
    press(1'b1, 1'b1);
    exp_on[exp_ptr] ^= 1'b1;
    exp_ptr = (exp_ptr + 1) % N;
    check_state("R10 toggle before step");
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog actual %0d cycles expected fewer", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_step_walk();
    t_toggles();
    t_debounce();
    t_simultaneous();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule